// File: doc/BRIEF.md
# Panel Register Write Sequencer over SPI

This block writes 16-bit configuration registers of a display controller over a write-only SPI link. Every register write goes out as two separately framed 24-bit transfers. The first is an index frame that names the register, and the second is a data frame that carries the value. Chip select falls for each frame and rises again between the two frames. The host can ask for one arbitrary write. It can also ask for one of three canned power sequences: power-up, shutdown or resume. The block then issues the needed writes in a fixed order without further help from the host.

The host pulses `wr_start` with an address and a value, or pulses `seq_req` with a sequence selector. The orientation and colour-order bits of the output-control value come from `panel_mode`, which is sampled when the request is accepted. `busy` covers the whole job. `done` marks its end. A request that cannot be taken raises `err` for one cycle and changes nothing.

The controller FSM has three states. `C_IDLE` takes a request. `C_LAUNCH` starts one frame. `C_WAIT` waits for that frame to end and then either launches the next frame or returns to idle. The frame FSM has five states. `F_IDLE` loads the shifter and lowers chip select. `F_LOW` and `F_HIGH` are the two half periods of each bit. `F_HOLD` keeps chip select low for one half period after the last falling clock edge. `F_GAP` keeps chip select high for one half period before the frame reports that it has finished.

Top module: `panel_regwr_seq`

## Requirements
- R1: An index frame is 24 bits sent under one low period of `spi_cs_n`. Its bytes, in order, are 0x74, 0x00 and the register address, MSB first.
- R2: A data frame is 24 bits under one low period of `spi_cs_n`. Its bytes, in order, are 0x76, the value's high byte and the value's low byte, MSB first.
- R3: `spi_cs_n` returns high between the index frame and the data frame. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_cs_n` is low only while `busy` is high.
- R4: The link uses SPI mode 0. `spi_mosi` does not change while `spi_sclk` is high. Each clock half period lasts `HALF_CYCLES` system clocks, so `spi_sclk` is high for 24×`HALF_CYCLES` clocks per frame.
- R5: `wr_start` with no `seq_req` sends exactly one index/data frame pair, carrying `wr_addr` and `wr_value`.
- R6: `seq_req` with `seq_sel`=0 (power-up) writes register 0x11 = 0x0000 and then writes register 0x01 = the output-control value.
- R7: The output-control value is (`panel_mode` & 0x0B00) | 0x20EF. This is 0x2AEF with bits 11, 9 and 8 taken from the mode.
- R8: `seq_sel`=1 (shutdown) sends one write, register 0x11 = 0x0001.
- R9: `seq_sel`=2 (resume) writes register 0x01 = the output-control value and then writes register 0x11 = 0x0000.
- R10: `busy` rises in the cycle after a request is accepted. It stays high until the job ends. `done` is high for exactly one cycle, which is the first cycle with `busy` low again.
- R11: A request that arrives while `busy` is high raises `err` for the next cycle and is ignored. The running job's frames are unchanged.
- R12: `seq_sel`=3, or `wr_start` and `seq_req` together, raises `err` for the next cycle. No frame is sent and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Pulse: write one register |
| wr_addr | input | 8 | Register address for a single write |
| wr_value | input | 16 | Value for a single write |
| seq_req | input | 1 | Pulse: run a canned sequence |
| seq_sel | input | 2 | 0 power-up, 1 shutdown, 2 resume, 3 invalid |
| panel_mode | input | 16 | Source of the orientation/colour-order bits |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | One-cycle pulse for a rejected request |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI serial data out |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
`busy` and `err` are registered, so both respond at the first clock edge after the request edge. The bench drives requests on falling clock edges and samples these outputs on the next falling edge. The bench then reads `busy` on every falling edge until it sees `done`. `done` must appear in the same sample in which `busy` first reads low, and it must be gone one sample later. A small serial monitor rebuilds the frames from the SPI pins, sampling `spi_mosi` on rising `spi_sclk` and closing a frame on rising `spi_cs_n`. Frame contents are therefore checked only after the job has ended, and no check depends on a particular edge-to-bit latency.

// File: rtl/prw_pkg.sv
package prw_pkg;
    localparam int FRAME_BITS = 24;
    localparam int BIT_CW     = $clog2(FRAME_BITS);

    localparam logic [7:0]  IDX_PREFIX  = 8'h74;
    localparam logic [7:0]  DAT_PREFIX  = 8'h76;
    localparam logic [7:0]  REG_POWER   = 8'h11;
    localparam logic [7:0]  REG_OUTCTL  = 8'h01;
    localparam logic [15:0] OUTCTL_BASE = 16'h2AEF;
    localparam logic [15:0] POWER_ON    = 16'h0000;
    localparam logic [15:0] POWER_OFF   = 16'h0001;

    typedef enum logic [1:0] {
        JOB_SINGLE,
        JOB_PWRUP,
        JOB_OFF,
        JOB_RESUME
    } job_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_LAUNCH,
        C_WAIT
    } ctl_state_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LOW,
        F_HIGH,
        F_HOLD,
        F_GAP
    } frm_state_e;

    typedef struct packed {
        logic [7:0]  addr;
        logic [15:0] value;
    } reg_wr_t;

    function automatic logic job_last(input job_e job);
        return (job == JOB_PWRUP) || (job == JOB_RESUME);
    endfunction

    function automatic reg_wr_t job_step(input job_e job, input logic step,
                                         input reg_wr_t host, input logic [15:0] outctl);
        reg_wr_t w;
        unique case (job)
            JOB_SINGLE: w = host;
            JOB_PWRUP:  w = step ? '{REG_OUTCTL, outctl} : '{REG_POWER, POWER_ON};
            JOB_OFF:    w = '{REG_POWER, POWER_OFF};
            JOB_RESUME: w = step ? '{REG_POWER, POWER_ON} : '{REG_OUTCTL, outctl};
            default:    w = host;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/prw_half_tick.sv
module prw_half_tick #(
    parameter int HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    generate
        if (HALF_CYCLES == 1) begin : g_every
            assign tick = run;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt <= '0;
                else        cnt <= '0;
            end
        end else begin : g_count
            assign tick = run && (cnt == LAST);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           cnt <= '0;
                else if (!run || tick) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/prw_frame_tx.sv
module prw_frame_tx
    import prw_pkg::*;
#(
    parameter int HALF_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  frame_done,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  cs_n
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_BITS - 1);

    frm_state_e            state, nxt;
    logic                  tick;
    logic [FRAME_BITS-1:0] sreg;
    logic [BIT_CW-1:0]     bit_cnt;
    logic                  sclk_q, cs_q, done_q;

    prw_half_tick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != F_IDLE),
        .tick (tick)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            F_IDLE: if (start) nxt = F_LOW;
            F_LOW:  if (tick)  nxt = F_HIGH;
            F_HIGH: if (tick)  nxt = (bit_cnt == LAST_BIT) ? F_HOLD : F_LOW;
            F_HOLD: if (tick)  nxt = F_GAP;
            F_GAP:  if (tick)  nxt = F_IDLE;
            default:           nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg    <= '0;
            bit_cnt <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                F_IDLE: if (start) begin
                    sreg    <= word;
                    bit_cnt <= '0;
                    cs_q    <= 1'b0;
                end
                F_LOW: if (tick) sclk_q <= 1'b1;
                F_HIGH: if (tick) begin
                    sclk_q <= 1'b0;
                    if (bit_cnt != LAST_BIT) begin
                        sreg    <= {sreg[FRAME_BITS-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                F_HOLD: if (tick) cs_q <= 1'b1;
                F_GAP:  if (tick) done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        sclk       = sclk_q;
        cs_n       = cs_q;
        mosi       = sreg[FRAME_BITS-1];
        frame_done = done_q;
    end
endmodule

// File: rtl/prw_job_ctl.sv
module prw_job_ctl
    import prw_pkg::*;
#(
    parameter logic [15:0] MODE_MASK = 16'h0B00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_start,
    input  logic [7:0]            wr_addr,
    input  logic [15:0]           wr_value,
    input  logic                  seq_req,
    input  logic [1:0]            seq_sel,
    input  logic [15:0]           panel_mode,
    input  logic                  frame_done,
    output logic                  frame_start,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  busy,
    output logic                  done,
    output logic                  err
);
    ctl_state_e  state, nxt;
    job_e        job_q;
    reg_wr_t     host_q;
    logic [15:0] mode_q;
    logic        step_q, phase_q;
    logic        done_q, err_q;
    logic        req_any, req_ok, last_pair;
    reg_wr_t     cur;
    logic [15:0] outctl;

    assign req_any   = wr_start | seq_req;
    assign req_ok    = (wr_start && !seq_req) || (seq_req && !wr_start && seq_sel != 2'd3);
    assign last_pair = phase_q && (step_q == job_last(job_q));
    assign outctl    = (mode_q & MODE_MASK) | (OUTCTL_BASE & ~MODE_MASK);
    assign cur       = job_step(job_q, step_q, host_q, outctl);

    always_comb begin
        nxt = state;
        unique case (state)
            C_IDLE:   if (req_ok) nxt = C_LAUNCH;
            C_LAUNCH: nxt = C_WAIT;
            C_WAIT:   if (frame_done) nxt = last_pair ? C_IDLE : C_LAUNCH;
            default:  nxt = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= C_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            job_q   <= JOB_SINGLE;
            host_q  <= '0;
            mode_q  <= '0;
            step_q  <= 1'b0;
            phase_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= req_any && (state != C_IDLE || !req_ok);
            unique case (state)
                C_IDLE: if (req_ok) begin
                    host_q  <= '{wr_addr, wr_value};
                    mode_q  <= panel_mode;
                    step_q  <= 1'b0;
                    phase_q <= 1'b0;
                    if (wr_start) job_q <= JOB_SINGLE;
                    else begin
                        unique case (seq_sel)
                            2'd0:    job_q <= JOB_PWRUP;
                            2'd1:    job_q <= JOB_OFF;
                            default: job_q <= JOB_RESUME;
                        endcase
                    end
                end
                C_WAIT: if (frame_done) begin
                    if (!phase_q) phase_q <= 1'b1;
                    else if (last_pair) done_q <= 1'b1;
                    else begin
                        phase_q <= 1'b0;
                        step_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy        = (state != C_IDLE);
        frame_start = (state == C_LAUNCH);
        frame_word  = phase_q ? {DAT_PREFIX, cur.value} : {IDX_PREFIX, 8'h00, cur.addr};
        done        = done_q;
        err         = err_q;
    end
endmodule

// File: rtl/panel_regwr_seq.sv
module panel_regwr_seq
    import prw_pkg::*;
#(
    parameter int          HALF_CYCLES = 2,
    parameter logic [15:0] MODE_MASK   = 16'h0B00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_start,
    input  logic [7:0]  wr_addr,
    input  logic [15:0] wr_value,
    input  logic        seq_req,
    input  logic [1:0]  seq_sel,
    input  logic [15:0] panel_mode,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n
);
    logic                  frame_start, frame_done;
    logic [FRAME_BITS-1:0] frame_word;

    prw_job_ctl #(.MODE_MASK(MODE_MASK)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .wr_addr    (wr_addr),
        .wr_value   (wr_value),
        .seq_req    (seq_req),
        .seq_sel    (seq_sel),
        .panel_mode (panel_mode),
        .frame_done (frame_done),
        .frame_start(frame_start),
        .frame_word (frame_word),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );

    prw_frame_tx #(.HALF_CYCLES(HALF_CYCLES)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_start),
        .word      (frame_word),
        .frame_done(frame_done),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .cs_n      (spi_cs_n)
    );
endmodule

// File: rtl/panel_regwr_seq_chk.sv
module panel_regwr_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_start,
    input logic        seq_req,
    input logic [1:0]  seq_sel,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        spi_sclk,
    input logic        spi_mosi,
    input logic        spi_cs_n
);
    // R3
    cs_idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R3
    cs_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R4
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R10
    done_at_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_start || seq_req)) |=> err);

    // R12
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && seq_req && !wr_start && seq_sel == 2'd3) |=> (err && !busy));

    // R12
    both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && seq_req && wr_start) |=> (err && !busy));
endmodule

bind panel_regwr_seq panel_regwr_seq_chk u_chk (.*);

// File: tb/panel_regwr_seq_test.sv
module panel_regwr_seq_test;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_value = '0;
    logic        seq_req = 1'b0;
    logic [1:0]  seq_sel = '0;
    logic [15:0] panel_mode = '0;
    logic        busy, done, err, spi_sclk, spi_mosi, spi_cs_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    panel_regwr_seq #(.HALF_CYCLES(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .wr_value(wr_value), .seq_req(seq_req), .seq_sel(seq_sel),
        .panel_mode(panel_mode), .busy(busy), .done(done), .err(err),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    // serial monitor
    logic [23:0] shin;
    int          nbits;
    logic [23:0] fr [0:15];
    int          fr_bits [0:15];
    int          nfr = 0;
    int          hi_clks = 0;

    always @(negedge spi_cs_n) begin shin = '0; nbits = 0; end
    always @(posedge spi_sclk) if (!spi_cs_n) begin shin = {shin[22:0], spi_mosi}; nbits++; end
    always @(posedge spi_cs_n) if (rst_n && nfr < 16) begin fr[nfr] = shin; fr_bits[nfr] = nbits; nfr++; end
    always @(posedge clk) if (spi_sclk) hi_clks++;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        nfr = 0;
        hi_clks = 0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        int drops = 0;
        @(negedge clk);
        chk(busy === 1'b1, {tag, " R10 busy rise"}, busy, 1);
        while (done !== 1'b1 && n < 20000) begin
            if (busy !== 1'b1) drops++;
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1 && drops == 0, {tag, " R10 busy held to done"}, drops, 0);
        chk(busy === 1'b0, {tag, " R10 busy low at done"}, busy, 0);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R10 done one cycle"}, done, 0);
    endtask

    task automatic check_pair(input int k, input logic [7:0] a, input logic [15:0] v, input string tag);
        chk(fr[2*k] === {8'h74, 8'h00, a} && fr_bits[2*k] == 24,
            {tag, " R1 index frame"}, fr[2*k], {8'h74, 8'h00, a});
        chk(fr[2*k+1] === {8'h76, v} && fr_bits[2*k+1] == 24,
            {tag, " R2 data frame"}, fr[2*k+1], {8'h76, v});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_addr = a; wr_value = v; wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic do_seq(input logic [1:0] s, input logic [15:0] m);
        @(negedge clk);
        seq_sel = s; panel_mode = m; seq_req = 1'b1;
        @(negedge clk);
        seq_req = 1'b0;
        panel_mode = 16'h1234;
    endtask

    // single-write vectors: {addr, value}
    localparam logic [23:0] VEC [0:4] = '{
        {8'h00, 16'h0000}, {8'hFF, 16'hFFFF}, {8'h5A, 16'hA5C3},
        {8'h11, 16'h0001}, {8'h80, 16'h0180}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R3 reset idle pins", {spi_cs_n, spi_sclk}, 2'b10);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10 reset flags", {busy, done, err}, 0);

        // R5 table-driven single writes
        foreach (VEC[i]) begin
            clear_mon();
            do_write(VEC[i][23:16], VEC[i][15:0]);
            wait_done("R5 vec");
            chk(nfr == 2, "R5 frame count", nfr, 2);
            check_pair(0, VEC[i][23:16], VEC[i][15:0], "R5 vec");
            chk(hi_clks == 2 * 24 * HALF, "R4 sclk high time", hi_clks, 2 * 24 * HALF);
        end

        // R6 R7 power-up with all mode bits set
        clear_mon();
        do_seq(2'd0, 16'hFFFF);
        wait_done("R6");
        chk(nfr == 4, "R6 frame count", nfr, 4);
        check_pair(0, 8'h11, 16'h0000, "R6 step0");
        check_pair(1, 8'h01, 16'h2BEF, "R6 R7 step1");

        // R7 mode bits clear
        clear_mon();
        do_seq(2'd0, 16'h0000);
        wait_done("R7");
        check_pair(1, 8'h01, 16'h20EF, "R7 mask clear");

        // R8 shutdown
        clear_mon();
        do_seq(2'd1, 16'hFFFF);
        wait_done("R8");
        chk(nfr == 2, "R8 frame count", nfr, 2);
        check_pair(0, 8'h11, 16'h0001, "R8");

        // R9 resume, mode 0x0A00
        clear_mon();
        do_seq(2'd2, 16'h0A00);
        wait_done("R9");
        chk(nfr == 4, "R9 frame count", nfr, 4);
        check_pair(0, 8'h01, 16'h2AEF, "R9 R7 step0");
        check_pair(1, 8'h11, 16'h0000, "R9 step1");

        // R11 request while busy
        clear_mon();
        do_write(8'h3C, 16'hBEEF);
        repeat (10) @(negedge clk);
        seq_sel = 2'd1; seq_req = 1'b1;
        @(negedge clk);
        seq_req = 1'b0;
        chk(err === 1'b1, "R11 err while busy", err, 1);
        @(negedge clk);
        chk(err === 1'b0, "R11 err one cycle", err, 0);
        wait_done("R11");
        chk(nfr == 2, "R11 frame count", nfr, 2);
        check_pair(0, 8'h3C, 16'hBEEF, "R11 unchanged");

        // R12 invalid selector
        clear_mon();
        @(negedge clk);
        seq_sel = 2'd3; seq_req = 1'b1;
        @(negedge clk);
        seq_req = 1'b0;
        chk(err === 1'b1 && busy === 1'b0, "R12 bad sel", {err, busy}, 2'b10);
        repeat (300) @(negedge clk);
        chk(nfr == 0 && spi_cs_n === 1'b1, "R12 no frames bad sel", nfr, 0);

        // R12 both requests together
        @(negedge clk);
        seq_sel = 2'd0; seq_req = 1'b1; wr_start = 1'b1;
        @(negedge clk);
        seq_req = 1'b0; wr_start = 1'b0;
        chk(err === 1'b1 && busy === 1'b0, "R12 both req", {err, busy}, 2'b10);
        repeat (300) @(negedge clk);
        chk(nfr == 0, "R12 no frames both", nfr, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule